// File: doc/BRIEF.md
# Binary to Base-Two Logarithm Converter

This block turns a 16-bit unsigned integer into a fixed-point approximation of its base-two logarithm. It uses the piecewise-linear approximation. The position of the most significant set bit becomes the integer part. The bits below that bit, shifted up to the top of the fraction field, stand in for the fractional part directly, and no correction term is applied. An input of zero has no logarithm, so it raises a separate flag instead.

The datapath has three parts. A leading-one detector is built from 4-bit priority groups. A binary multiplexer tree then picks out the winning group's local position. A logarithmic left shifter normalises the mantissa, and its shift amount comes from the encoded position. The input and the output are both registered. A sample offered with its valid strobe is captured at one rising edge, and its result appears with an output strobe after the next rising edge. A new sample can be accepted on every cycle.

The result format is a 4-bit integer part and a 15-bit fraction. Fraction bit 14 carries the input bit just below the leading one. Fraction bit 13 carries the next bit down, and so on. Fraction positions that no input bit reaches are filled with zeros.

Top module: `log2_conv`

## Requirements
- R1: For a nonzero input, `out_int` equals the bit index (0 to 15) of the most significant 1 in the input.
- R2: For a nonzero input whose leading one is at index p, `out_frac[14-k]` equals input bit p-1-k for k = 0 to p-1. All lower fraction bits are 0. Equivalently, `out_frac` is bits 14:0 of the input shifted left by 15-p.
- R3: For an input of 0, `out_zero` is 1 and `out_int` and `out_frac` are both 0. For any nonzero input, `out_zero` is 0.
- R4: A sample presented with `in_valid` high before rising edge k is captured at edge k. Its result, with `out_valid` high for one cycle, is visible after edge k+1. Samples presented on consecutive cycles produce results on consecutive cycles, in the same order.
- R5: While `rst` is high at a rising edge, `out_valid`, `out_zero`, `out_int` and `out_frac` are all cleared to 0 by that edge, and any sample in flight is discarded.
- R6: An input of 29 gives `out_int` = 4 and `out_frac` = 0x6800, which is the fraction bits 1101 followed by zeros.
- R7: An input of 1 gives integer 0 and fraction 0. An input of 0xFFFF gives integer 15 and fraction 0x7FFF.
- R8: When no sample is presented, `out_valid` drops to 0 and `out_int`, `out_frac` and `out_zero` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` for capture at the next edge |
| in_data | input | 16 | Unsigned integer operand |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_int | output | 4 | Integer part of the logarithm (leading-one index) |
| out_frac | output | 15 | Fraction part, normalised mantissa bits, zero-filled below |
| out_zero | output | 1 | Set when the result belongs to a zero input |

## Verification
The bench sweeps all 65536 operands back to back. It also checks the boundaries at each 4-bit group edge, because a priority error in the group select would report a lower group's position for an input that spans two groups. A shift amount that is off by one would show up at 0x8000, 0xFFFF and 0x7FFF: the fraction would lose its top bit or pick up the leading one. Zero input is checked for a flag with zeroed fields, since a design that skipped the forcing would report a garbage position of 0. The bench also checks hold, discard and latency behaviour: idle cycles, which a design that updated its outputs every cycle would corrupt, and a reset that arrives with a sample in flight, which a design that leaked the stale strobe would get wrong.

// File: rtl/log2c_pkg.sv
package log2c_pkg;

    // Operand width, and the widths of the result fields derived from it.
    localparam int DATA_W = 16;
    localparam int GRP_W  = 4;
    localparam int INT_W  = $clog2(DATA_W);
    localparam int FRAC_W = DATA_W - 1;

    typedef struct packed {
        logic              zero;
        logic [INT_W-1:0]  ipart;
        logic [FRAC_W-1:0] frac;
    } log_result_t;

    typedef struct packed {
        logic              in_v;
        logic [DATA_W-1:0] in_d;
        logic              out_v;
        log_result_t       res;
    } log_state_t;

endpackage

// File: rtl/log2c_lod_group.sv
// Priority detector for one slice: one-hot marking of the highest set bit.
module log2c_lod_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] onehot,
    output logic         any
);

    always_comb begin
        onehot = '0;
        // The scan runs upward, so the highest set bit wins.
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                onehot = W'(1) << i;
            end
        end
        any = |vec;
    end

endmodule

// File: rtl/log2c_enc.sv
// One-hot to binary index encoder.
module log2c_enc #(
    parameter  int W  = 4,
    localparam int OW = $clog2(W)
) (
    input  logic [W-1:0]  onehot,
    output logic [OW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) begin
                idx = idx | OW'(i);
            end
        end
    end

endmodule

// File: rtl/log2c_lod.sv
// Hierarchical leading-one detector: priority groups, a group select,
// and a 2:1 multiplexer tree that forwards the winning local index.
module log2c_lod #(
    parameter  int DATA_W = 16,
    parameter  int GRP_W  = 4,
    localparam int NG     = DATA_W / GRP_W,
    localparam int GB     = $clog2(GRP_W),
    localparam int SB     = $clog2(NG),
    localparam int PW     = GB + SB
) (
    input  logic [DATA_W-1:0] vec,
    output logic [PW-1:0]     pos,
    output logic              any
);

    logic [GRP_W-1:0] grp_oh  [NG];
    logic [NG-1:0]    grp_any;
    logic [GB-1:0]    grp_pos [NG];
    logic [NG-1:0]    sel_oh;
    logic [SB-1:0]    sel_pos;

    // Heap-ordered mux tree: node 0 is the root, leaves are NG-1 .. 2NG-2.
    logic [GB-1:0]    node [2*NG-1];

    for (genvar g = 0; g < NG; g++) begin : g_grp
        log2c_lod_group #(.W(GRP_W)) u_grp (
            .vec    (vec[g*GRP_W +: GRP_W]),
            .onehot (grp_oh[g]),
            .any    (grp_any[g])
        );
        log2c_enc #(.W(GRP_W)) u_enc (
            .onehot (grp_oh[g]),
            .idx    (grp_pos[g])
        );
        assign node[NG-1+g] = grp_pos[g];
    end

    log2c_lod_group #(.W(NG)) u_sel (
        .vec    (grp_any),
        .onehot (sel_oh),
        .any    (any)
    );

    log2c_enc #(.W(NG)) u_sel_enc (
        .onehot (sel_oh),
        .idx    (sel_pos)
    );

    for (genvar n = 0; n < NG-1; n++) begin : g_mux
        localparam int DEPTH = $clog2(n + 2) - 1;
        assign node[n] = sel_pos[SB-1-DEPTH] ? node[2*n+2] : node[2*n+1];
    end

    assign pos = {sel_pos, node[0]};

endmodule

// File: rtl/log2c_shifter.sv
// Logarithmic left shifter: stage s moves the word by 2**s when amt[s] is set.
module log2c_shifter #(
    parameter  int W  = 16,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stg [SW+1];

    assign stg[0] = din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        assign stg[s+1] = amt[s] ? (stg[s] << (2**s)) : stg[s];
    end

    assign dout = stg[SW];

endmodule

// File: rtl/log2_conv.sv
module log2_conv
    import log2c_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_data,
    output logic                out_valid,
    output logic [INT_W-1:0]    out_int,
    output logic [FRAC_W-1:0]   out_frac,
    output logic                out_zero
);

    log_state_t        st_d, st_q;
    logic [INT_W-1:0]  lead_pos;
    logic              lead_any;
    logic [INT_W-1:0]  shift_amt;
    logic [DATA_W-1:0] shifted;

    log2c_lod #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_lod (
        .vec (st_q.in_d),
        .pos (lead_pos),
        .any (lead_any)
    );

    // The shift that brings the leading one up to the top bit.
    assign shift_amt = INT_W'(DATA_W - 1) - lead_pos;

    log2c_shifter #(.W(DATA_W)) u_shift (
        .din  (st_q.in_d),
        .amt  (shift_amt),
        .dout (shifted)
    );

    always_comb begin
        st_d       = st_q;
        st_d.in_v  = in_valid;
        if (in_valid) begin
            st_d.in_d = in_data;
        end
        st_d.out_v = st_q.in_v;
        if (st_q.in_v) begin
            st_d.res.zero  = ~lead_any;
            st_d.res.ipart = lead_any ? lead_pos : '0;
            st_d.res.frac  = lead_any ? shifted[FRAC_W-1:0] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_v;
    assign out_int   = st_q.res.ipart;
    assign out_frac  = st_q.res.frac;
    assign out_zero  = st_q.res.zero;

    // R2: after normalisation the leading one must sit in the top bit.
    a_r2_norm_top: assert property (@(posedge clk) disable iff (rst)
        (st_q.in_d != '0) |-> shifted[DATA_W-1]);

    // R1: the reported index must point at the highest set bit of the operand.
    a_r1_lead_index: assert property (@(posedge clk) disable iff (rst)
        (st_q.in_v && st_q.in_d != '0) |=> (($past(st_q.in_d) >> out_int) == DATA_W'(1)));

    // R3: a zero result carries no integer or fraction bits.
    a_r3_zero_fields: assert property (@(posedge clk) disable iff (rst)
        out_zero |-> (out_int == '0 && out_frac == '0));

    // R4: every strobe at the output traces back two edges to an accepted input.
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R8: with nothing captured, the result registers hold and the strobe drops.
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !st_q.in_v |=> (!out_valid && $stable(out_int) && $stable(out_frac) && $stable(out_zero)));

endmodule

// File: tb/sim_log2_conv.sv
module sim_log2_conv;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_data;
    logic        out_valid;
    logic [3:0]  out_int;
    logic [14:0] out_frac;
    logic        out_zero;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    log2_conv u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_int   (out_int),
        .out_frac  (out_frac),
        .out_zero  (out_zero)
    );

    // Table entry: {operand[15:0], zero, int[3:0], frac[14:0]}
    localparam int NTBL = 12;
    localparam logic [35:0] TBL [NTBL] = '{
        {16'h0000, 1'b1, 4'd0,  15'h0000},  // R3 zero
        {16'h0001, 1'b0, 4'd0,  15'h0000},  // R7 smallest
        {16'h0002, 1'b0, 4'd1,  15'h0000},
        {16'h0003, 1'b0, 4'd1,  15'h4000},
        {16'd29,   1'b0, 4'd4,  15'h6800},  // R6
        {16'h00FF, 1'b0, 4'd7,  15'h7F00},
        {16'h0100, 1'b0, 4'd8,  15'h0000},
        {16'h1234, 1'b0, 4'd12, 15'h11A0},
        {16'h4001, 1'b0, 4'd14, 15'h0002},
        {16'h7FFF, 1'b0, 4'd14, 15'h7FFE},
        {16'h8000, 1'b0, 4'd15, 15'h0000},
        {16'hFFFF, 1'b0, 4'd15, 15'h7FFF}   // R7 largest
    };

    function automatic logic [19:0] model(input logic [15:0] x);
        int          p;
        logic [15:0] sh;
        p = -1;
        for (int i = 0; i < 16; i++) begin
            if (x[i]) p = i;
        end
        if (p < 0) return {1'b1, 4'd0, 15'd0};
        sh = x << (15 - p);
        return {1'b0, 4'(p), sh[14:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_res(input string req, input logic [15:0] x, input logic [19:0] e);
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " zero"},  {31'd0, out_zero},  {31'd0, e[19]});
        check({req, " int"},   {28'd0, out_int},   {28'd0, e[18:15]});
        check({req, " frac"},  {17'd0, out_frac},  {17'd0, e[14:0]});
        if (act_bad(e)) $display("  operand=%h", x);
    endtask

    function automatic bit act_bad(input logic [19:0] e);
        return {out_zero, out_int, out_frac} !== e;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        repeat (3) @(negedge clk);
        // R5: reset state
        check("R5 reset valid", {31'd0, out_valid}, 32'd0);
        check("R5 reset fields", {12'd0, out_zero, out_int, out_frac}, 32'd0);
        rst = 1'b0;

        // Table walk, one sample at a time: R1 R2 R3 R6 R7 R4
        for (int t = 0; t < NTBL; t++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = TBL[t][35:20];
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 16'hDEAD;
            check("R4 not early", {31'd0, out_valid}, 32'd0);
            @(negedge clk);
            check_res("R1 R2 R3 table", TBL[t][35:20], TBL[t][19:0]);
        end

        // R8: idle cycles hold the last result (0xFFFF) and drop the strobe
        repeat (4) begin
            @(negedge clk);
            in_data = 16'h0005;
        end
        check("R8 hold valid", {31'd0, out_valid}, 32'd0);
        check("R8 hold fields", {12'd0, out_zero, out_int, out_frac}, {12'd0, 1'b0, 4'd15, 15'h7FFF});

        // R5: reset with a sample in flight discards it
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'h0040;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R5 flush valid", {31'd0, out_valid}, 32'd0);
        check("R5 flush fields", {12'd0, out_zero, out_int, out_frac}, 32'd0);
        @(negedge clk);
        check("R5 no stale strobe", {31'd0, out_valid}, 32'd0);

        // Exhaustive back-to-back sweep: R1 R2 R3 R4 ordering
        for (int i = 0; i < 65538; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check_res("R1 R2 R3 R4 sweep", 16'(i - 2), model(16'(i - 2)));
            end
            if (i < 65536) begin
                in_valid = 1'b1;
                in_data  = 16'(i);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R8 strobe drops", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule